// File: doc/BRIEF.md
# Mailbox-Commanded I2C Master

This block is an I2C bus master run by a host through four 16-bit registers. To write, the host loads one or two payload bytes into a write-extension register and then writes a command word. The command holds the 7-bit target address, the direction, a length of one or two bytes, a mode field and a bus-hold flag. The block runs the transfer on open-drain SCL and SDA, given as active-high pull-low enables. Bytes read from the target land in a read-extension register. The end of each command is reported through sticky event bits, which the host clears by writing ones.

A command with the hold flag set leaves SCL pulled low and issues no STOP. The next command then opens with a repeated START, so one device access can be split across several commands: for example, a register-pointer write followed by a read. A one-byte read with hold clear acts as a presence probe, because an absent device leaves the address unacknowledged and the error event is raised. The register interface has no stream data path. Every register access completes in the cycle it is presented and never stalls, so there is no valid/ready handshake and no back-pressure. A command that arrives while the engine is busy is dropped.

Register map by `reg_addr`:
- 0: command (write starts a transfer; read returns the last accepted command word)
- 1: write extension
- 2: read extension (read only)
- 3: status (events in bits 15:13, busy in bit 0; writing clears events)

Top module: `i2c_mailbox_master`

## Requirements
- R1: In a command word, bits 7:1 give the 7-bit target address, bit 10 set means write and clear means read, and bit 11 set means two data bytes, otherwise one. Only a mode field (bits 15:14) equal to 2 starts a transfer. Any other mode value leaves the bus, busy and the events untouched.
- R2: A write sends the address byte with R/W=0, then write-extension bits 7:0, then, for a two-byte write, bits 15:8. The extension is captured when the command is accepted.
- R3: For a read, the first received byte is stored in read-extension bits 7:0 and the second in bits 15:8. A one-byte read leaves bits 15:8 unchanged.
- R4: Status bit 13 is the error event, bit 14 the transmit-complete event and bit 15 the receive-complete event. A successful write sets only bit 14, a successful read sets only bit 15, and a failed command sets only bit 13. Events stay set until cleared.
- R5: Writing status with a bit set to 1 clears that event. Event bits written as 0 keep their value.
- R6: A NACK of the address byte or of any written data byte raises the error event and ends the command with a STOP, even when hold was requested.
- R7: Command bit 13 set holds the bus. At the end there is no STOP, SCL stays pulled low with SDA released, and the next command begins with a repeated START.
- R8: During reads the master ACKs every byte except the last byte of a command. That last byte is NACKed when hold is clear and ACKed when hold is set.
- R9: Status bit 0 reads 1 while a command runs. A command written while busy is ignored.
- R10: Both line enables are released after reset and after every STOP. Outside START and STOP conditions, SDA changes only while SCL is pulled low. Each bit lasts four quarter periods of QDIV clocks, with SCL released for the middle two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions watch, on every cycle, that SDA holds steady while SCL is released inside address and data bits. They also check that an error completion leaves both lines released and the engine idle, that busy only rises after a native-mode command write, and that events never fall except by a status write, which does clear the bits written as one. Only the bench's scenarios can show end-to-end effects. These are the byte order on the wire and in the read extension, the ACK and NACK pattern a target sees, the START and STOP counts across held and released commands, and that commands sent while busy or in a foreign mode leave no trace on the bus. The bench does this with a behavioural target that ACKs address 0x50, NACKs the data byte 0xEE and returns 0xA0, 0xA1 and so on after each START.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_DATA, ST_STOP
  } eng_st_e;

  localparam int CMD_WR_BIT   = 10;
  localparam int CMD_TWO_BIT  = 11;
  localparam int CMD_HOLD_BIT = 13;
  localparam logic [1:0] MODE_NATIVE = 2'b10;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_WEXT = 2'd1;
  localparam logic [1:0] RA_REXT = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        start,
  input  logic [6:0]  addr_i,
  input  logic        wr_i,
  input  logic        two_i,
  input  logic        hold_i,
  input  logic [15:0] wdat_i,
  input  logic        sda_in,
  output logic        busy,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        rx_we,
  output logic        rx_idx,
  output logic [7:0]  rx_byte,
  output logic        done_tx,
  output logic        done_rx,
  output logic        done_err
);
  eng_st_e     st;
  logic [1:0]  q;
  logic [3:0]  bitn;
  logic [7:0]  sh;
  logic [15:0] wd_r;
  logic        bidx, wr_r, two_r, hold_r, held, err_r, smp;

  logic last_byte, drive_data;
  assign last_byte  = (bidx == two_r);
  assign drive_data = (st == ST_ADDR) || wr_r;
  assign busy       = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; q <= '0; bitn <= '0; sh <= '0; wd_r <= '0;
      bidx <= 1'b0; wr_r <= 1'b0; two_r <= 1'b0; hold_r <= 1'b0;
      held <= 1'b0; err_r <= 1'b0; smp <= 1'b1;
      rx_we <= 1'b0; rx_idx <= 1'b0; rx_byte <= '0;
      done_tx <= 1'b0; done_rx <= 1'b0; done_err <= 1'b0;
    end else begin
      rx_we <= 1'b0; done_tx <= 1'b0; done_rx <= 1'b0; done_err <= 1'b0;
      if (start && st == ST_IDLE) begin
        st <= ST_START; q <= '0; bitn <= '0; bidx <= 1'b0; err_r <= 1'b0;
        wr_r <= wr_i; two_r <= two_i; hold_r <= hold_i; wd_r <= wdat_i;
        sh <= {addr_i, ~wr_i};
      end else if (tick && st != ST_IDLE) begin
        q <= q + 2'd1;
        if (q == 2'd2) smp <= sda_in;
        if (q == 2'd3) begin
          case (st)
            ST_START: begin st <= ST_ADDR; bitn <= '0; held <= 1'b0; end
            ST_ADDR, ST_DATA: begin
              if (bitn != 4'd8) begin
                sh   <= {sh[6:0], smp};
                bitn <= bitn + 4'd1;
                if (st == ST_DATA && !wr_r && bitn == 4'd7) begin
                  rx_we <= 1'b1; rx_byte <= {sh[6:0], smp}; rx_idx <= bidx;
                end
              end else if (drive_data && smp) begin
                err_r <= 1'b1; st <= ST_STOP;
              end else if (st == ST_ADDR) begin
                st <= ST_DATA; bitn <= '0; sh <= wr_r ? wd_r[7:0] : 8'hFF;
              end else if (!last_byte) begin
                bidx <= 1'b1; bitn <= '0; sh <= wr_r ? wd_r[15:8] : 8'hFF;
              end else if (hold_r) begin
                st <= ST_IDLE; held <= 1'b1; done_tx <= wr_r; done_rx <= !wr_r;
              end else begin
                st <= ST_STOP;
              end
            end
            ST_STOP: begin
              st <= ST_IDLE; held <= 1'b0;
              done_err <= err_r;
              done_tx  <= !err_r && wr_r;
              done_rx  <= !err_r && !wr_r;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      ST_IDLE:  scl_oe = held;
      ST_START: begin
        scl_oe = (q == 2'd0) ? held : (q == 2'd3);
        sda_oe = q[1];
      end
      ST_ADDR, ST_DATA: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        if (bitn == 4'd8) sda_oe = drive_data ? 1'b0 : !(last_byte && !hold_r);
        else              sda_oe = drive_data && !sh[7];
      end
      ST_STOP: begin
        scl_oe = (q == 2'd0);
        sda_oe = !q[1];
      end
      default: ;
    endcase
  end

  // R10
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (st == ST_ADDR || st == ST_DATA)
     && ($past(st) == ST_ADDR || $past(st) == ST_DATA)) |-> $stable(sda_oe));

  // R6
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> (!scl_oe && !sda_oe && !busy));
endmodule

// File: rtl/i2c_mailbox_master.sv
module i2c_mailbox_master
  import i2cm_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  logic [15:0] cmd_q, wext_q, rext_q;
  logic [2:0]  ev_q;
  logic        busy, tick, accept, cmd_wr, stat_wr;
  logic        rx_we, rx_idx, done_tx, done_rx, done_err;
  logic [7:0]  rx_byte;

  assign cmd_wr  = reg_wr && reg_addr == RA_CMD;
  assign stat_wr = reg_wr && reg_addr == RA_STAT;
  assign accept  = cmd_wr && !busy && reg_wdata[15:14] == MODE_NATIVE;

  i2cm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(accept),
    .addr_i(reg_wdata[7:1]), .wr_i(reg_wdata[CMD_WR_BIT]),
    .two_i(reg_wdata[CMD_TWO_BIT]), .hold_i(reg_wdata[CMD_HOLD_BIT]),
    .wdat_i(wext_q), .sda_in(sda_in), .busy(busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_byte(rx_byte), .done_tx(done_tx), .done_rx(done_rx), .done_err(done_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; wext_q <= '0; rext_q <= '0; ev_q <= '0;
    end else begin
      if (accept) cmd_q <= reg_wdata;
      if (reg_wr && reg_addr == RA_WEXT) wext_q <= reg_wdata;
      if (rx_we) begin
        if (rx_idx) rext_q[15:8] <= rx_byte;
        else        rext_q[7:0]  <= rx_byte;
      end
      ev_q <= (stat_wr ? (ev_q & ~reg_wdata[15:13]) : ev_q)
              | {done_rx, done_tx, done_err};
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CMD:  reg_rdata = cmd_q;
      RA_WEXT: reg_rdata = wext_q;
      RA_REXT: reg_rdata = rext_q;
      default: reg_rdata = {ev_q, 12'd0, busy};
    endcase
  end

  // R4
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[13] && !done_err) |=> !ev_q[0]);

  // R9
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == RA_CMD && reg_wdata[15:14] == MODE_NATIVE));
endmodule

// File: tb/i2c_mailbox_master_tb.sv
module i2c_mailbox_master_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic tgt_sda_oe = 1'b0;
  logic scl_line, sda_line;

  always #2 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || tgt_sda_oe);

  i2c_mailbox_master #(.QDIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // behavioural target at 0x50
  int starts = 0, stops = 0, wcnt = 0, rcnt = 0;
  logic [7:0] wlog [64];
  logic       racks [64];
  bit t_act = 0, t_first = 0, t_addr = 0, t_sel = 0, t_rw = 0, t_mnack = 0;
  int t_cnt = 0, t_n = 0;
  logic [7:0] t_sh = 8'd0;

  function automatic logic [7:0] rdb(input int n);
    return 8'hA0 + 8'(n);
  endfunction

  always @(negedge sda_line) if (scl_line) begin
    starts++; t_act = 1; t_first = 1; t_cnt = 0; t_addr = 1; t_sel = 0; t_n = 0;
    tgt_sda_oe = 0;
  end

  always @(posedge sda_line) if (scl_line && t_act) begin
    stops++; t_act = 0; tgt_sda_oe = 0;
  end

  always @(posedge scl_line) if (t_act) begin
    if (t_cnt < 8) t_sh = {t_sh[6:0], sda_line};
    else if (t_sel && t_rw && !t_addr) begin
      racks[rcnt % 64] = sda_line; rcnt++; t_mnack = sda_line;
    end
  end

  always @(negedge scl_line) if (t_act) begin
    if (t_first) t_first = 0;
    else if (t_cnt < 7) begin
      t_cnt++;
      if (t_sel && t_rw && !t_addr) tgt_sda_oe = !rdb(t_n)[7 - t_cnt];
    end else if (t_cnt == 7) begin
      t_cnt = 8;
      if (t_addr) begin
        t_sel = (t_sh[7:1] == 7'h50); t_rw = t_sh[0]; tgt_sda_oe = t_sel;
      end else if (t_sel && !t_rw) begin
        wlog[wcnt % 64] = t_sh; wcnt++; tgt_sda_oe = (t_sh != 8'hEE);
      end else tgt_sda_oe = 0;
    end else begin
      t_cnt = 0; tgt_sda_oe = 0;
      if (t_sel && t_rw) begin
        if (t_addr) tgt_sda_oe = !rdb(t_n)[7];
        else if (!t_mnack) begin t_n++; tgt_sda_oe = !rdb(t_n)[7]; end
        else t_sel = 0;
      end
      t_addr = 0;
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    int n;
    s = 16'h1; n = 0;
    while (s[0] && n < 20000) begin rdreg(2'd3, s); n++; end
    if (n >= 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 busy never cleared got %h exp 0000", s);
    end
  endtask

  task automatic run(input logic [15:0] cmd, input logic [15:0] wext);
    wr(2'd1, wext); wr(2'd3, 16'hE000); wr(2'd0, cmd);
    wait_idle();
  endtask

  typedef struct packed {
    logic [15:0] cmd, wext, ev, rd, rmask;
    logic [1:0]  nw;
    logic [7:0]  w0, w1;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h84A0, 16'h005A, 16'h4000, 16'h0000, 16'h0000, 2'd1, 8'h5A, 8'h00},
    '{16'h8CA0, 16'h3412, 16'h4000, 16'h0000, 16'h0000, 2'd2, 8'h12, 8'h34},
    '{16'h80A0, 16'h0000, 16'h8000, 16'h00A0, 16'h00FF, 2'd0, 8'h00, 8'h00},
    '{16'h88A0, 16'h0000, 16'h8000, 16'hA1A0, 16'hFFFF, 2'd0, 8'h00, 8'h00},
    '{16'h8046, 16'h0000, 16'h2000, 16'h0000, 16'h0000, 2'd0, 8'h00, 8'h00},
    '{16'h8446, 16'h0055, 16'h2000, 16'h0000, 16'h0000, 2'd0, 8'h00, 8'h00},
    '{16'h84A0, 16'h00EE, 16'h2000, 16'h0000, 16'h0000, 2'd1, 8'hEE, 8'h00},
    '{16'h8CA0, 16'hEE11, 16'h2000, 16'h0000, 16'h0000, 2'd2, 8'h11, 8'hEE}
  };

  initial begin
    #(150000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run hung got %h exp %h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int s0, p0, w0, r0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state, R10 released lines
    rdreg(2'd3, d); check("R9 reset status", d, 16'h0000);
    rdreg(2'd2, d); check("R3 reset read ext", d, 16'h0000);
    check("R10 reset lines", {14'd0, scl_oe, sda_oe}, 16'h0000);

    // vector table: R1 R2 R3 R4 R6 R10
    for (int i = 0; i < 8; i++) begin
      s0 = starts; p0 = stops; w0 = wcnt;
      run(VECS[i].cmd, VECS[i].wext);
      rdreg(2'd3, d); check("R4 events", d, VECS[i].ev);
      rdreg(2'd2, d); check("R3 read ext", d & VECS[i].rmask, VECS[i].rd & VECS[i].rmask);
      check("R2 bytes logged", 16'(wcnt - w0), 16'(VECS[i].nw));
      if (VECS[i].nw >= 2'd1) check("R2 first byte", 16'(wlog[w0 % 64]), 16'(VECS[i].w0));
      if (VECS[i].nw == 2'd2) check("R2 second byte", 16'(wlog[(w0 + 1) % 64]), 16'(VECS[i].w1));
      check("R6 one stop", 16'(stops - p0), 16'd1);
      check("R1 one start", 16'(starts - s0), 16'd1);
      check("R10 lines released", {14'd0, scl_oe, sda_oe}, 16'h0000);
    end

    // R8: two-byte read without hold acks first, nacks second
    r0 = rcnt;
    run(16'h88A0, 16'h0000);
    check("R8 ack pattern", {14'd0, racks[r0 % 64], racks[(r0 + 1) % 64]}, 16'h0001);

    // R3: one-byte read keeps upper half
    run(16'h80A0, 16'h0000);
    rdreg(2'd2, d); check("R3 upper kept", d, 16'hA1A0);

    // R1: foreign mode ignored
    wr(2'd3, 16'hE000);
    s0 = starts;
    wr(2'd0, 16'hC4A0);
    repeat (40) @(negedge clk);
    rdreg(2'd3, d); check("R1 foreign mode", d, 16'h0000);
    check("R1 no bus activity", 16'(starts - s0), 16'd0);

    // R9: command while busy ignored
    s0 = starts; w0 = wcnt;
    wr(2'd1, 16'h005A); wr(2'd0, 16'h84A0);
    rdreg(2'd3, d); check("R9 busy bit", d & 16'h0001, 16'h0001);
    wr(2'd0, 16'h80A0);
    wait_idle();
    rdreg(2'd3, d); check("R9 ignored cmd events", d, 16'h4000);
    check("R9 ignored cmd starts", 16'(starts - s0), 16'd1);
    rdreg(2'd0, d); check("R9 command readback", d, 16'h84A0);

    // R4 sticky, R5 clear by ones
    wr(2'd0, 16'h80A0); wait_idle();
    rdreg(2'd3, d); check("R4 sticky both", d, 16'hC000);
    wr(2'd3, 16'h4000);
    rdreg(2'd3, d); check("R5 clear one", d, 16'h8000);
    wr(2'd3, 16'h8000);
    rdreg(2'd3, d); check("R5 clear rest", d, 16'h0000);

    // R7: held write then repeated-start read
    s0 = starts; p0 = stops; w0 = wcnt; r0 = rcnt;
    run(16'hA4A0, 16'h0007);
    rdreg(2'd3, d); check("R7 held write events", d, 16'h4000);
    check("R7 no stop", 16'(stops - p0), 16'd0);
    check("R7 scl held, sda free", {14'd0, scl_oe, sda_oe}, 16'h0002);
    check("R7 held byte", 16'(wlog[w0 % 64]), 16'h0007);
    run(16'h88A0, 16'h0000);
    rdreg(2'd2, d); check("R7 read after repeated start", d, 16'hA1A0);
    check("R7 starts", 16'(starts - s0), 16'd2);
    check("R7 stops", 16'(stops - p0), 16'd1);

    // R8: held read acks its last byte
    r0 = rcnt;
    run(16'hA0A0, 16'h0000);
    check("R8 held last ack", {15'd0, racks[r0 % 64]}, 16'h0000);
    run(16'h80A0, 16'h0000);
    check("R8 released last nack", {15'd0, racks[(r0 + 1) % 64]}, 16'h0001);

    // R6: address NACK under hold still stops
    p0 = stops;
    run(16'hA446, 16'h0055);
    rdreg(2'd3, d); check("R6 held nack events", d, 16'h2000);
    check("R6 held nack stop", 16'(stops - p0), 16'd1);
    check("R6 lines released", {14'd0, scl_oe, sda_oe}, 16'h0000);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule